// File: doc/BRIEF.md
# Serial Command Word Register Loader

This block accepts 16-bit command words on a three-wire serial port: an active-low frame select, a serial clock and a data line. Bits are taken most significant first on falling serial-clock edges while the frame is open. Each completed word is handed across to the core clock domain, where its two top bits pick a destination. The destination is either a 14-bit control register, one of two 28-bit frequency registers or one of two 12-bit phase registers.

A frequency register can be loaded in two ways, chosen by a control bit. In full-width mode two consecutive words supply the lower and then the upper 14 bits, and the register changes only once, after the second word. In half mode each word replaces a single 14-bit half, chosen by a second control bit. The register contents are presented as outputs in the core clock domain for a downstream oscillator.

Top module: `serial_reg_writer`

## Requirements
- R1: Data is sampled on each falling edge of `ser_clk` while `frame_n` is low and assembled most significant bit first. A word is complete after 16 such edges.
- R2: While `frame_n` stays low, every further group of 16 falling edges forms another complete word, and each of these words is decoded in turn.
- R3: If `frame_n` rises before the 16th edge of a word, the partial word is dropped and no output changes. The next frame starts a fresh word.
- R4: Word bits 15:14 select the destination. 00 selects control, 01 selects frequency 0, 10 selects frequency 1 and 11 selects phase. For a phase word, bit 13 picks phase 0 (0) or phase 1 (1), bits 11:0 are the value and bit 12 is ignored.
- R5: A control word stores its bits 13:0 into `ctrl_o`, except that positions 9, 4, 2 and 0 always read 0. Bit 13 is the full-width flag and bit 12 is the upper-half flag. Bit 11 selects the frequency, bit 10 the phase, bit 8 holds the output at zero, bit 7 stops the clock, bit 6 turns off the converter, bit 5 enables the bit output, bit 3 halves the output and bit 1 selects ramp.
- R6: With control bit 13 set, the first frequency word stages its bits 13:0 as the lower half and leaves the register unchanged. The second word loads {its bits 13:0, staged half} into the register it addresses. Example: 0x2000, 0x4000, 0x7FFF leaves frequency 0 at 0xFFFC000.
- R7: With control bit 13 clear, a frequency word replaces the upper 14 bits when control bit 12 is 1 and the lower 14 bits when it is 0. The other half is kept.
- R8: A control word discards a staged first half, so the next frequency word is again treated as a first half.
- R9: While `rst` is high at a rising `clk` edge, all output registers and the staged state become zero.
- R10: A completed word takes effect no later than the fourth rising `clk` edge after its 16th falling edge. Outputs change only when a word completes.
- R11: A phase word leaves both frequency registers and any staged first half unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset, also clears the serial-side handoff |
| frame_n | input | 1 | Active-low frame select |
| ser_clk | input | 1 | Serial clock, data sampled on falling edge |
| ser_data | input | 1 | Serial data, most significant bit first |
| ctrl_o | output | 14 | Control register |
| freq0_o | output | 28 | Frequency register 0 |
| freq1_o | output | 28 | Frequency register 1 |
| phase0_o | output | 12 | Phase register 0 |
| phase1_o | output | 12 | Phase register 1 |

## Verification
Several rules are checked on every core cycle. Registers hold their value unless a word has just arrived. A phase word never disturbs the frequency registers or the staged half. A control word always empties the staging slot. A second full-width word puts its payload into the upper half and consumes the staged half. Some behaviour lives on the serial side or spans several words, and only the bench scenarios show it. This covers bit order, packing several words into one frame, dropping an aborted partial word, the exact value of a two-word load and the worst-case handoff latency.

// File: rtl/serial_reg_writer_pkg.sv
package serial_reg_writer_pkg;

    localparam int WORD_W  = 16;
    localparam int FREQ_W  = 28;
    localparam int PHASE_W = 12;
    localparam int HALF_W  = FREQ_W / 2;
    localparam int CTRL_W  = WORD_W - 2;
    localparam int CNT_W   = $clog2(WORD_W);

    typedef enum logic [1:0] {
        DST_CTRL  = 2'b00,
        DST_FREQ0 = 2'b01,
        DST_FREQ1 = 2'b10,
        DST_PHASE = 2'b11
    } dst_e;

    typedef struct packed {
        logic full_load;   // 13
        logic upper_half;  // 12
        logic freq_pick;   // 11
        logic phase_pick;  // 10
        logic rsv9;
        logic hold_zero;   // 8
        logic clk_stop;    // 7
        logic dac_off;     // 6
        logic bit_out;     // 5
        logic rsv4;
        logic halve;       // 3
        logic rsv2;
        logic ramp;        // 1
        logic rsv0;
    } ctrl_t;

    function automatic ctrl_t mask_ctrl(input logic [CTRL_W-1:0] bits);
        ctrl_t c;
        c      = ctrl_t'(bits);
        c.rsv9 = 1'b0;
        c.rsv4 = 1'b0;
        c.rsv2 = 1'b0;
        c.rsv0 = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/ser_word_shifter.sv
module ser_word_shifter
    import serial_reg_writer_pkg::*;
(
    input  logic              rst,
    input  logic              frame_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    output logic [WORD_W-1:0] word_o,
    output logic              tgl_o
);

    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-2:0] shreg;
    logic              last_bit;

    assign last_bit = (bit_cnt == CNT_W'(WORD_W - 1));

    // An open frame keeps this running; a high frame select clears it.
    always_ff @(negedge ser_clk or posedge frame_n) begin
        if (frame_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
            shreg   <= {shreg[WORD_W-3:0], ser_data};
        end
    end

    // Completed word is held steady and announced by a toggle.
    always_ff @(negedge ser_clk or posedge rst) begin
        if (rst) begin
            word_o <= '0;
            tgl_o  <= 1'b0;
        end else if (!frame_n && last_bit) begin
            word_o <= {shreg, ser_data};
            tgl_o  <= ~tgl_o;
        end
    end

endmodule

// File: rtl/toggle_pulse_sync.sv
module toggle_pulse_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tgl_i,
    output logic pulse_o
);

    localparam int LEN = STAGES + 1;

    logic [LEN-1:0] chain;

    generate
        for (genvar g = 0; g < LEN; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= tgl_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign pulse_o = chain[LEN-1] ^ chain[LEN-2];

endmodule

// File: rtl/cmd_word_decoder.sv
module cmd_word_decoder
    import serial_reg_writer_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               stb,
    input  logic [WORD_W-1:0]  word,
    output ctrl_t              ctrl_q,
    output logic [FREQ_W-1:0]  freq0_q,
    output logic [FREQ_W-1:0]  freq1_q,
    output logic [PHASE_W-1:0] phase0_q,
    output logic [PHASE_W-1:0] phase1_q,
    output logic               pend_q
);

    dst_e              dst;
    logic [HALF_W-1:0] payload;
    logic [HALF_W-1:0] stage_q;
    logic [FREQ_W-1:0] freq_cur;
    logic [FREQ_W-1:0] freq_nxt;

    assign dst      = dst_e'(word[WORD_W-1:WORD_W-2]);
    assign payload  = word[HALF_W-1:0];
    assign freq_cur = (dst == DST_FREQ1) ? freq1_q : freq0_q;

    always_comb begin
        if (ctrl_q.full_load)       freq_nxt = {payload, stage_q};
        else if (ctrl_q.upper_half) freq_nxt = {payload, freq_cur[HALF_W-1:0]};
        else                        freq_nxt = {freq_cur[FREQ_W-1:HALF_W], payload};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            freq0_q  <= '0;
            freq1_q  <= '0;
            phase0_q <= '0;
            phase1_q <= '0;
            stage_q  <= '0;
            pend_q   <= 1'b0;
        end else if (stb) begin
            case (dst)
                DST_CTRL: begin
                    ctrl_q <= mask_ctrl(word[CTRL_W-1:0]);
                    pend_q <= 1'b0;
                end
                DST_FREQ0, DST_FREQ1: begin
                    if (ctrl_q.full_load && !pend_q) begin
                        stage_q <= payload;
                        pend_q  <= 1'b1;
                    end else begin
                        pend_q <= 1'b0;
                        if (dst == DST_FREQ1) freq1_q <= freq_nxt;
                        else                  freq0_q <= freq_nxt;
                    end
                end
                default: begin
                    if (word[WORD_W-3]) phase1_q <= word[PHASE_W-1:0];
                    else                phase0_q <= word[PHASE_W-1:0];
                end
            endcase
        end
    end

endmodule

// File: rtl/serial_reg_writer.sv
module serial_reg_writer
    import serial_reg_writer_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_n,
    input  logic               ser_clk,
    input  logic               ser_data,
    output logic [CTRL_W-1:0]  ctrl_o,
    output logic [FREQ_W-1:0]  freq0_o,
    output logic [FREQ_W-1:0]  freq1_o,
    output logic [PHASE_W-1:0] phase0_o,
    output logic [PHASE_W-1:0] phase1_o
);

    logic [WORD_W-1:0] word_cdc;
    logic              word_tgl;
    logic              word_stb;
    logic              pend_half;
    ctrl_t             ctrl_s;

    ser_word_shifter u_shift (
        .rst      (rst),
        .frame_n  (frame_n),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .word_o   (word_cdc),
        .tgl_o    (word_tgl)
    );

    toggle_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .tgl_i   (word_tgl),
        .pulse_o (word_stb)
    );

    cmd_word_decoder u_dec (
        .clk      (clk),
        .rst      (rst),
        .stb      (word_stb),
        .word     (word_cdc),
        .ctrl_q   (ctrl_s),
        .freq0_q  (freq0_o),
        .freq1_q  (freq1_o),
        .phase0_q (phase0_o),
        .phase1_q (phase1_o),
        .pend_q   (pend_half)
    );

    assign ctrl_o = ctrl_s;

endmodule

// File: rtl/serial_reg_writer_chk.sv
module serial_reg_writer_chk
    import serial_reg_writer_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               stb,
    input logic [WORD_W-1:0]  word,
    input logic [CTRL_W-1:0]  ctrl,
    input logic [FREQ_W-1:0]  freq0,
    input logic [FREQ_W-1:0]  freq1,
    input logic [PHASE_W-1:0] phase0,
    input logic [PHASE_W-1:0] phase1,
    input logic               pend
);

    p_quiet_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !stb |=> $stable(ctrl) && $stable(freq0) && $stable(freq1)
                 && $stable(phase0) && $stable(phase1) && $stable(pend));

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        stb |=> !stb);

    p_phase_isolated_r11: assert property (@(posedge clk) disable iff (rst)
        stb && word[15:14] == 2'b11 |=> $stable(freq0) && $stable(freq1) && $stable(pend));

    p_ctrl_clears_stage_r8: assert property (@(posedge clk) disable iff (rst)
        stb && word[15:14] == 2'b00 |=> !pend);

    p_second_half_r6: assert property (@(posedge clk) disable iff (rst)
        stb && word[15:14] == 2'b01 && ctrl[13] && pend
        |=> !pend && freq0[27:14] == $past(word[13:0]));

    p_upper_keeps_lower_r7: assert property (@(posedge clk) disable iff (rst)
        stb && word[15:14] == 2'b10 && !ctrl[13] && ctrl[12]
        |=> freq1[13:0] == $past(freq1[13:0]) && freq1[27:14] == $past(word[13:0]));

    p_reserved_low_r5: assert property (@(posedge clk) disable iff (rst)
        stb && word[15:14] == 2'b00 |=> ctrl[9] == 1'b0 && ctrl[4] == 1'b0);

endmodule

bind serial_reg_writer serial_reg_writer_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .stb    (word_stb),
    .word   (word_cdc),
    .ctrl   (ctrl_o),
    .freq0  (freq0_o),
    .freq1  (freq1_o),
    .phase0 (phase0_o),
    .phase1 (phase1_o),
    .pend   (pend_half)
);

// File: tb/test_serial_reg_writer.sv
`timescale 1ns/1ps
module test_serial_reg_writer;

    typedef struct {
        int          which;   // 0 ctrl, 1 f0, 2 f1, 3 p0, 4 p1
        logic [27:0] val;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_n = 1'b1;
    logic        ser_clk = 1'b1;
    logic        ser_data = 1'b0;
    logic [13:0] ctrl_o;
    logic [27:0] freq0_o, freq1_o;
    logic [11:0] phase0_o, phase1_o;

    int   n_chk = 0;
    int   n_fail = 0;
    exp_t sb[$];

    always #4 clk = ~clk;

    serial_reg_writer i_serial_reg_writer (
        .clk(clk), .rst(rst), .frame_n(frame_n), .ser_clk(ser_clk),
        .ser_data(ser_data), .ctrl_o(ctrl_o), .freq0_o(freq0_o),
        .freq1_o(freq1_o), .phase0_o(phase0_o), .phase1_o(phase1_o)
    );

    function automatic logic [27:0] pick(input int which);
        case (which)
            0: pick = {14'd0, ctrl_o};
            1: pick = freq0_o;
            2: pick = freq1_o;
            3: pick = {16'd0, phase0_o};
            default: pick = {16'd0, phase1_o};
        endcase
    endfunction

    task automatic check(input int which, input logic [27:0] exp, input string tag);
        logic [27:0] act;
        act = pick(which);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s reg%0d actual=0x%07h expected=0x%07h", tag, which, act, exp);
        end
    endtask

    task automatic expect_reg(input int which, input logic [27:0] v, input string tag);
        exp_t e;
        e.which = which; e.val = v; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic settle();
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    // Monitor: lets the handoff finish, then compares every queued item.
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                repeat (8) @(negedge clk);
                while (sb.size() > 0) begin
                    exp_t e;
                    e = sb.pop_front();
                    check(e.which, e.val, e.tag);
                end
            end
        end
    end

    task automatic shift_bits(input logic [15:0] w, input int nbits);
        for (int i = 15; i > 15 - nbits; i--) begin
            ser_data = w[i];
            #32 ser_clk = 1'b0;
            #32 ser_clk = 1'b1;
        end
    endtask

    task automatic open_frame();
        ser_clk = 1'b1;
        #10 frame_n = 1'b0;
        #10;
    endtask

    task automatic close_frame();
        #10 frame_n = 1'b1;
        #20;
    endtask

    task automatic send1(input logic [15:0] w);
        open_frame();
        shift_bits(w, 16);
        close_frame();
    endtask

    task automatic send2(input logic [15:0] a, input logic [15:0] b);
        open_frame();
        shift_bits(a, 16);
        shift_bits(b, 16);
        close_frame();
    endtask

    task automatic expect_all_zero(input string tag);
        for (int k = 0; k < 5; k++) expect_reg(k, 28'd0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        expect_all_zero("R9 reset state");
        settle();

        // R5 R1: control word, reserved bits cleared
        send1(16'h3FFF);
        expect_reg(0, 28'h0003DEA, "R5 reserved bits read zero");
        settle();

        // R6: two-write load, no intermediate value
        send1(16'h2000);
        expect_reg(0, 28'h0002000, "R5 control 0x2000");
        settle();
        send1(16'h4000);
        expect_reg(1, 28'h0000000, "R6 first half not visible");
        settle();
        send1(16'h7FFF);
        expect_reg(1, 28'hFFFC000, "R6 complete load 0xFFFC000");
        settle();

        // R2: two words in one frame; R7 lower half
        send2(16'h0000, 16'h8123);
        expect_reg(0, 28'h0000000, "R2 first word of frame");
        expect_reg(2, 28'h0000123, "R7 lower half write");
        settle();
        send2(16'h1000, 16'hBFFF);
        expect_reg(2, 28'hFFFC123, "R7 upper half keeps lower");
        expect_reg(1, 28'hFFFC000, "R4 freq0 untouched by freq1 write");
        settle();

        // R8: control word drops the staged half
        send1(16'h2000);
        send1(16'h4001);
        send1(16'h2000);
        send1(16'h4002);
        expect_reg(1, 28'hFFFC000, "R8 restart staging, no update");
        settle();
        send1(16'h4003);
        expect_reg(1, 28'h000C002, "R8 load after discard");
        settle();

        // R4: phase writes, bit 12 ignored
        send2(16'hDABC, 16'hE123);
        expect_reg(3, 28'h0000ABC, "R4 phase0 write");
        expect_reg(4, 28'h0000123, "R4 phase1 write");
        settle();

        // R11: phase word between halves
        send1(16'h4005);
        send1(16'hC777);
        expect_reg(1, 28'h000C002, "R11 freq0 unchanged by phase");
        expect_reg(3, 28'h0000777, "R11 phase0 updated");
        settle();
        send1(16'h4006);
        expect_reg(1, 28'h0018005, "R11 staged half survived phase");
        settle();

        // R3: aborted partial word
        open_frame();
        shift_bits(16'h0FFF, 5);
        close_frame();
        expect_reg(0, 28'h0002000, "R3 partial word dropped");
        settle();
        send1(16'h0800);
        expect_reg(0, 28'h0000800, "R3 fresh word after abort");
        settle();

        // R10: latency bound, half mode lower write to freq1
        open_frame();
        shift_bits(16'h8055, 16);
        repeat (4) @(posedge clk);
        #1 check(2, 28'hFFFC055, "R10 update within four core edges");
        close_frame();

        // R9: reset mid-run
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        expect_all_zero("R9 reset clears all");
        settle();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule